// File: doc/BRIEF.md
# Bidirectional dual-clock FIFO pair

This block joins two clock domains, port A and port B, with a pair of first-in first-out buffers that carry data in opposite directions. Words written at port A are read at port B, and words written at port B are read at port A. Each port has its own free-running clock. The two clocks may be unrelated, or they may be one and the same clock, with writes and reads landing on the same edge.

Each buffer stores 64 words of 36 bits. It keeps binary and gray-coded pointers, and the gray-coded copy of each pointer is passed through a two-flop synchronizer into the other domain. Every buffer reports four flags. Full and almost-full are registered in its write domain. Empty and almost-empty are registered in its read domain. The almost flags compare the stored word count, or the free space, against 6-bit offsets. A port loads these offsets through a small configuration input, and only while that port is held in reset.

Both port resets are synchronous and active high. They are meant to be asserted together and to overlap for several cycles of each clock.

Top module: `bidir_fifo_pair`

## Requirements
- R1: Words written at port A come out at port B, and words written at port B come out at port A. Each direction keeps the order of its words exactly, and traffic in one direction has no effect on the other.
- R2: Each buffer accepts exactly 64 words of 36 bits. Full rises on the write-clock edge that accepts the 64th stored word, and it stays low while fewer than 64 words are stored.
- R3: A write offered while full is high is dropped. The stored words are not changed, and after draining, exactly the 64 words that were stored earlier come out, in order.
- R4: A read offered while empty is high is dropped. The read data output keeps its value, empty stays high, and the next word written is the next word read.
- R5: After reset, empty is high. Empty falls a few read-clock cycles after a word has been written. It rises again only through a read that takes the last stored word.
- R6: Almost-empty is high exactly when the stored word count is at or below the almost-empty offset. With the default offset of 8, it is high with 8 words stored and low with 9.
- R7: Almost-full is high exactly when the free space (64 minus the stored count) is at or below the almost-full offset. With the default offset of 8, it is low with 55 words stored and high with 56.
- R8: A port loads offsets through `x_cfg_we`, `x_cfg_sel` and `x_cfg_val`, and only in cycles where that port's reset is high. Select 0 loads the almost-empty offset of the buffer this port reads. Select 1 loads the almost-full offset of the buffer this port writes. Writes made while reset is low are ignored. In the first cycle of every reset, each offset returns to 8, unless it is loaded in that same cycle.
- R9: Read data is registered. An accepted read presents its word on the read-clock edge that accepts it, and the read data output changes only on an accepted read.
- R10: Data moves correctly whether the two clocks are unrelated or identical. This holds with simultaneous writes and reads on both buffers, including cycles in which a buffer is full or empty.
- R11: Reset drives full and almost-full low, and empty and almost-empty high, in both buffers. It also clears both read data outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| a_wr_en | input | 1 | Write request into the A-to-B buffer |
| a_wr_data | input | 36 | Write word for the A-to-B buffer |
| a_full | output | 1 | A-to-B buffer full |
| a_afull | output | 1 | A-to-B buffer almost full |
| a_rd_en | input | 1 | Read request from the B-to-A buffer |
| a_rd_data | output | 36 | Registered read word from the B-to-A buffer |
| a_empty | output | 1 | B-to-A buffer empty |
| a_aempty | output | 1 | B-to-A buffer almost empty |
| a_cfg_we | input | 1 | Offset load strobe for port A (honoured only in reset) |
| a_cfg_sel | input | 1 | 0: B-to-A almost-empty offset, 1: A-to-B almost-full offset |
| a_cfg_val | input | 6 | Offset value to load |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| b_wr_en | input | 1 | Write request into the B-to-A buffer |
| b_wr_data | input | 36 | Write word for the B-to-A buffer |
| b_full | output | 1 | B-to-A buffer full |
| b_afull | output | 1 | B-to-A buffer almost full |
| b_rd_en | input | 1 | Read request from the A-to-B buffer |
| b_rd_data | output | 36 | Registered read word from the A-to-B buffer |
| b_empty | output | 1 | A-to-B buffer empty |
| b_aempty | output | 1 | A-to-B buffer almost empty |
| b_cfg_we | input | 1 | Offset load strobe for port B (honoured only in reset) |
| b_cfg_sel | input | 1 | 0: A-to-B almost-empty offset, 1: B-to-A almost-full offset |
| b_cfg_val | input | 6 | Offset value to load |

## Verification
The hard case is a write and a read on the same buffer in one cycle while that buffer sits at a boundary. For example, a write may be held asserted against a full buffer on the same edge that a read frees a slot, or a read may arrive on the edge that a write first makes the buffer non-empty. This is provoked by holding write enable high across full, and starting the readers late, while both directions run at once, first with the two clocks tied together and then with them unrelated. The scoreboard judges each word against the queue of words the bench saw accepted, so a dropped, duplicated or reordered word in either direction is reported.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

  // Offset select codes on the per-port configuration input
  typedef enum logic {
    SEL_LOW_MARK  = 1'b0,  // almost-empty offset of the buffer this port reads
    SEL_HIGH_MARK = 1'b1   // almost-full offset of the buffer this port writes
  } mark_sel_e;

endpackage

// File: rtl/bfp_sync.sv
module bfp_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/bfp_ram.sv
module bfp_ram #(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port with synchronous output reset
  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/bfp_channel.sv
module bfp_channel #(
  parameter int DW          = 36,
  parameter int AW          = 6,
  parameter int SYNC_STAGES = 2,
  parameter int OFS_DEFAULT = 8
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  input  logic          af_cfg_we,
  input  logic [AW-1:0] af_cfg_val,
  output logic          full,
  output logic          afull,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          ren,
  input  logic          ae_cfg_we,
  input  logic [AW-1:0] ae_cfg_val,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          aempty
);

  localparam int            PW       = AW + 1;
  localparam int            DEPTH    = 1 << AW;
  localparam logic [PW-1:0] DEPTH_P  = PW'(DEPTH);
  localparam logic [AW-1:0] OFS_INIT = AW'(OFS_DEFAULT);

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0] wbin, wgray, wbin_n, wgray_n;
  logic [PW-1:0] rgray_s, rbin_s, used_n, free_n;
  logic          w_ok, full_q, afull_q;
  logic [AW-1:0] af_ofs;
  logic          w_in_rst = 1'b0;

  assign w_ok    = wen & ~full_q;
  assign wbin_n  = wbin + PW'(w_ok);
  assign wgray_n = wbin_n ^ (wbin_n >> 1);
  assign rbin_s  = gray2bin(rgray_s);
  assign used_n  = wbin_n - rbin_s;
  assign free_n  = DEPTH_P - used_n;

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin    <= '0;
      wgray   <= '0;
      full_q  <= 1'b0;
      afull_q <= 1'b0;
    end else begin
      wbin    <= wbin_n;
      wgray   <= wgray_n;
      full_q  <= (wgray_n == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
      afull_q <= (free_n <= {1'b0, af_ofs});
    end
  end

  always_ff @(posedge wclk) w_in_rst <= wrst;

  always_ff @(posedge wclk) begin
    if (wrst) begin
      if (af_cfg_we)      af_ofs <= af_cfg_val;
      else if (!w_in_rst) af_ofs <= OFS_INIT;
    end
  end

  bfp_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rptr_sync (
    .clk (wclk),
    .rst (wrst),
    .d   (rgray),
    .q   (rgray_s)
  );

  // ---------------- read domain ----------------
  logic [PW-1:0] rbin, rgray, rbin_n, rgray_n;
  logic [PW-1:0] wgray_s, wbin_s, cnt_n;
  logic          r_ok, empty_q, aempty_q;
  logic [AW-1:0] ae_ofs;
  logic          r_in_rst = 1'b0;

  assign r_ok    = ren & ~empty_q;
  assign rbin_n  = rbin + PW'(r_ok);
  assign rgray_n = rbin_n ^ (rbin_n >> 1);
  assign wbin_s  = gray2bin(wgray_s);
  assign cnt_n   = wbin_s - rbin_n;

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin     <= '0;
      rgray    <= '0;
      empty_q  <= 1'b1;
      aempty_q <= 1'b1;
    end else begin
      rbin     <= rbin_n;
      rgray    <= rgray_n;
      empty_q  <= (rgray_n == wgray_s);
      aempty_q <= (cnt_n <= {1'b0, ae_ofs});
    end
  end

  always_ff @(posedge rclk) r_in_rst <= rrst;

  always_ff @(posedge rclk) begin
    if (rrst) begin
      if (ae_cfg_we)      ae_ofs <= ae_cfg_val;
      else if (!r_in_rst) ae_ofs <= OFS_INIT;
    end
  end

  bfp_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wptr_sync (
    .clk (rclk),
    .rst (rrst),
    .d   (wgray),
    .q   (wgray_s)
  );

  // ---------------- storage ----------------
  bfp_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk  (wclk),
    .we    (w_ok),
    .waddr (wbin[AW-1:0]),
    .wdata (wdata),
    .rclk  (rclk),
    .rrst  (rrst),
    .re    (r_ok),
    .raddr (rbin[AW-1:0]),
    .rdata (rdata)
  );

  assign full   = full_q;
  assign afull  = afull_q;
  assign empty  = empty_q;
  assign aempty = aempty_q;

endmodule

// File: rtl/bidir_fifo_pair.sv
module bidir_fifo_pair
  import bfp_pkg::*;
#(
  parameter int DW          = 36,
  parameter int AW          = 6,
  parameter int SYNC_STAGES = 2,
  parameter int OFS_DEFAULT = 8
) (
  input  logic          clk_a,
  input  logic          rst_a,
  input  logic          a_wr_en,
  input  logic [DW-1:0] a_wr_data,
  output logic          a_full,
  output logic          a_afull,
  input  logic          a_rd_en,
  output logic [DW-1:0] a_rd_data,
  output logic          a_empty,
  output logic          a_aempty,
  input  logic          a_cfg_we,
  input  logic          a_cfg_sel,
  input  logic [AW-1:0] a_cfg_val,
  input  logic          clk_b,
  input  logic          rst_b,
  input  logic          b_wr_en,
  input  logic [DW-1:0] b_wr_data,
  output logic          b_full,
  output logic          b_afull,
  input  logic          b_rd_en,
  output logic [DW-1:0] b_rd_data,
  output logic          b_empty,
  output logic          b_aempty,
  input  logic          b_cfg_we,
  input  logic          b_cfg_sel,
  input  logic [AW-1:0] b_cfg_val
);

  // offset load strobes, steered by the select code of each port
  logic ab_hi_we, ab_lo_we, ba_hi_we, ba_lo_we;

  assign ab_hi_we = a_cfg_we && (a_cfg_sel == SEL_HIGH_MARK);
  assign ba_lo_we = a_cfg_we && (a_cfg_sel == SEL_LOW_MARK);
  assign ba_hi_we = b_cfg_we && (b_cfg_sel == SEL_HIGH_MARK);
  assign ab_lo_we = b_cfg_we && (b_cfg_sel == SEL_LOW_MARK);

  // A writes, B reads
  bfp_channel #(
    .DW(DW), .AW(AW), .SYNC_STAGES(SYNC_STAGES), .OFS_DEFAULT(OFS_DEFAULT)
  ) u_ab (
    .wclk       (clk_a),
    .wrst       (rst_a),
    .wen        (a_wr_en),
    .wdata      (a_wr_data),
    .af_cfg_we  (ab_hi_we),
    .af_cfg_val (a_cfg_val),
    .full       (a_full),
    .afull      (a_afull),
    .rclk       (clk_b),
    .rrst       (rst_b),
    .ren        (b_rd_en),
    .ae_cfg_we  (ab_lo_we),
    .ae_cfg_val (b_cfg_val),
    .rdata      (b_rd_data),
    .empty      (b_empty),
    .aempty     (b_aempty)
  );

  // B writes, A reads
  bfp_channel #(
    .DW(DW), .AW(AW), .SYNC_STAGES(SYNC_STAGES), .OFS_DEFAULT(OFS_DEFAULT)
  ) u_ba (
    .wclk       (clk_b),
    .wrst       (rst_b),
    .wen        (b_wr_en),
    .wdata      (b_wr_data),
    .af_cfg_we  (ba_hi_we),
    .af_cfg_val (b_cfg_val),
    .full       (b_full),
    .afull      (b_afull),
    .rclk       (clk_a),
    .rrst       (rst_a),
    .ren        (a_rd_en),
    .ae_cfg_we  (ba_lo_we),
    .ae_cfg_val (a_cfg_val),
    .rdata      (a_rd_data),
    .empty      (a_empty),
    .aempty     (a_aempty)
  );

endmodule

// File: rtl/bfp_checker.sv
module bfp_checker #(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input logic          clk_a,
  input logic          rst_a,
  input logic          a_wr_en,
  input logic [DW-1:0] a_wr_data,
  input logic          a_full,
  input logic          a_afull,
  input logic          a_rd_en,
  input logic [DW-1:0] a_rd_data,
  input logic          a_empty,
  input logic          a_aempty,
  input logic          a_cfg_we,
  input logic          a_cfg_sel,
  input logic [AW-1:0] a_cfg_val,
  input logic          clk_b,
  input logic          rst_b,
  input logic          b_wr_en,
  input logic [DW-1:0] b_wr_data,
  input logic          b_full,
  input logic          b_afull,
  input logic          b_rd_en,
  input logic [DW-1:0] b_rd_data,
  input logic          b_empty,
  input logic          b_aempty,
  input logic          b_cfg_we,
  input logic          b_cfg_sel,
  input logic [AW-1:0] b_cfg_val
);

  // ---- port A clock domain ----
  a_r11_a_reset_flags: assert property (@(posedge clk_a) disable iff (rst_a)
    $fell(rst_a) |-> (a_empty && a_aempty && !a_full && !a_afull && (a_rd_data == '0)));

  a_r3_a_full_has_afull: assert property (@(posedge clk_a) disable iff (rst_a)
    a_full |-> a_afull);

  a_r6_a_empty_has_aempty: assert property (@(posedge clk_a) disable iff (rst_a)
    a_empty |-> a_aempty);

  a_r2_a_full_after_write: assert property (@(posedge clk_a) disable iff (rst_a)
    $rose(a_full) |-> $past(a_wr_en));

  a_r5_a_empty_after_read: assert property (@(posedge clk_a) disable iff (rst_a)
    $rose(a_empty) |-> $past(a_rd_en));

  a_r4_a_read_on_empty: assert property (@(posedge clk_a) disable iff (rst_a)
    (a_rd_en && a_empty) |=> $stable(a_rd_data));

  a_r9_a_data_held: assert property (@(posedge clk_a) disable iff (rst_a)
    !a_rd_en |=> $stable(a_rd_data));

  // ---- port B clock domain ----
  a_r11_b_reset_flags: assert property (@(posedge clk_b) disable iff (rst_b)
    $fell(rst_b) |-> (b_empty && b_aempty && !b_full && !b_afull && (b_rd_data == '0)));

  a_r3_b_full_has_afull: assert property (@(posedge clk_b) disable iff (rst_b)
    b_full |-> b_afull);

  a_r6_b_empty_has_aempty: assert property (@(posedge clk_b) disable iff (rst_b)
    b_empty |-> b_aempty);

  a_r2_b_full_after_write: assert property (@(posedge clk_b) disable iff (rst_b)
    $rose(b_full) |-> $past(b_wr_en));

  a_r5_b_empty_after_read: assert property (@(posedge clk_b) disable iff (rst_b)
    $rose(b_empty) |-> $past(b_rd_en));

  a_r4_b_read_on_empty: assert property (@(posedge clk_b) disable iff (rst_b)
    (b_rd_en && b_empty) |=> $stable(b_rd_data));

  a_r9_b_data_held: assert property (@(posedge clk_b) disable iff (rst_b)
    !b_rd_en |=> $stable(b_rd_data));

endmodule

bind bidir_fifo_pair bfp_checker #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/tb_bidir_fifo_pair.sv
`timescale 1ns/1ps
module tb_bidir_fifo_pair;

  localparam int DW = 36;
  localparam int AW = 6;

  logic clk_a = 1'b0;
  logic clk_b_free = 1'b0;
  logic coinc = 1'b0;
  logic clk_b;
  always #4 clk_a = ~clk_a;            // 125 MHz
  always #3.5 clk_b_free = ~clk_b_free;
  assign clk_b = coinc ? clk_a : clk_b_free;

  logic          rst_a, rst_b;
  logic          a_wr_en, a_rd_en, a_cfg_we, a_cfg_sel;
  logic          b_wr_en, b_rd_en, b_cfg_we, b_cfg_sel;
  logic [DW-1:0] a_wr_data, b_wr_data, a_rd_data, b_rd_data;
  logic [AW-1:0] a_cfg_val, b_cfg_val;
  logic          a_full, a_afull, a_empty, a_aempty;
  logic          b_full, b_afull, b_empty, b_aempty;

  bidir_fifo_pair dut (
    .clk_a(clk_a), .rst_a(rst_a),
    .a_wr_en(a_wr_en), .a_wr_data(a_wr_data), .a_full(a_full), .a_afull(a_afull),
    .a_rd_en(a_rd_en), .a_rd_data(a_rd_data), .a_empty(a_empty), .a_aempty(a_aempty),
    .a_cfg_we(a_cfg_we), .a_cfg_sel(a_cfg_sel), .a_cfg_val(a_cfg_val),
    .clk_b(clk_b), .rst_b(rst_b),
    .b_wr_en(b_wr_en), .b_wr_data(b_wr_data), .b_full(b_full), .b_afull(b_afull),
    .b_rd_en(b_rd_en), .b_rd_data(b_rd_data), .b_empty(b_empty), .b_aempty(b_aempty),
    .b_cfg_we(b_cfg_we), .b_cfg_sel(b_cfg_sel), .b_cfg_val(b_cfg_val)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int seq    = 0;
  bit done   = 1'b0;
  logic [DW-1:0] qab[$];
  logic [DW-1:0] qba[$];

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word(input int k);
    return {4'(k), 32'(k * 32'h9E3779B1)};
  endfunction

  // ---- scoreboard monitors ----
  always begin : mon_b
    bit fire;
    logic [DW-1:0] e;
    @(posedge clk_b);
    fire = b_rd_en && !b_empty && !rst_b;
    @(negedge clk_b);
    if (fire) begin
      if (qab.size() == 0) chk(1'b0, "R1 A-to-B word with none expected", b_rd_data, '0);
      else begin
        e = qab.pop_front();
        chk(b_rd_data == e, "R1/R9 A-to-B word order", b_rd_data, e);
      end
    end
  end

  always begin : mon_a
    bit fire;
    logic [DW-1:0] e;
    @(posedge clk_a);
    fire = a_rd_en && !a_empty && !rst_a;
    @(negedge clk_a);
    if (fire) begin
      if (qba.size() == 0) chk(1'b0, "R1 B-to-A word with none expected", a_rd_data, '0);
      else begin
        e = qba.pop_front();
        chk(a_rd_data == e, "R1/R9 B-to-A word order", a_rd_data, e);
      end
    end
  end

  // ---- drivers ----
  task automatic wr_a(input bit expect_ok);
    logic [DW-1:0] d;
    d = word(seq); seq++;
    @(negedge clk_a);
    a_wr_en = 1'b1; a_wr_data = d;
    if (expect_ok) qab.push_back(d);
    @(negedge clk_a);
    a_wr_en = 1'b0;
  endtask

  task automatic wr_b(input bit expect_ok);
    logic [DW-1:0] d;
    d = word(seq); seq++;
    @(negedge clk_b);
    b_wr_en = 1'b1; b_wr_data = d;
    if (expect_ok) qba.push_back(d);
    @(negedge clk_b);
    b_wr_en = 1'b0;
  endtask

  // enable held high; a word counts as accepted only when full is low (R3)
  task automatic burst_a(input int n);
    int sent = 0;
    logic [DW-1:0] d;
    d = word(seq); seq++;
    while (sent < n) begin
      @(negedge clk_a);
      a_wr_en = 1'b1; a_wr_data = d;
      if (!a_full) begin
        qab.push_back(d); sent++;
        d = word(seq); seq++;
      end
    end
    @(negedge clk_a);
    a_wr_en = 1'b0;
  endtask

  task automatic burst_b(input int n);
    int sent = 0;
    logic [DW-1:0] d;
    d = word(seq); seq++;
    while (sent < n) begin
      @(negedge clk_b);
      b_wr_en = 1'b1; b_wr_data = d;
      if (!b_full) begin
        qba.push_back(d); sent++;
        d = word(seq); seq++;
      end
    end
    @(negedge clk_b);
    b_wr_en = 1'b0;
  endtask

  task automatic drain_b(input int n);
    int got = 0;
    while (got < n) begin
      @(negedge clk_b);
      b_rd_en = 1'b1;
      if (!b_empty) got++;
    end
    @(negedge clk_b);
    b_rd_en = 1'b0;
  endtask

  task automatic drain_a(input int n);
    int got = 0;
    while (got < n) begin
      @(negedge clk_a);
      a_rd_en = 1'b1;
      if (!a_empty) got++;
    end
    @(negedge clk_a);
    a_rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk_a);
    repeat (8) @(negedge clk_b);
  endtask

  task automatic do_reset(input bit same_clk, input bit load,
                          input int ae_a, input int af_a, input int ae_b, input int af_b);
    @(negedge clk_a);
    rst_a = 1'b1; rst_b = 1'b1;
    coinc = same_clk;
    repeat (4) @(negedge clk_a);
    repeat (4) @(negedge clk_b);
    if (load) begin
      @(negedge clk_a);
      a_cfg_we = 1'b1; a_cfg_sel = 1'b0; a_cfg_val = AW'(ae_a);
      @(negedge clk_a);
      a_cfg_sel = 1'b1; a_cfg_val = AW'(af_a);
      @(negedge clk_a);
      a_cfg_we = 1'b0;
      @(negedge clk_b);
      b_cfg_we = 1'b1; b_cfg_sel = 1'b0; b_cfg_val = AW'(ae_b);
      @(negedge clk_b);
      b_cfg_sel = 1'b1; b_cfg_val = AW'(af_b);
      @(negedge clk_b);
      b_cfg_we = 1'b0;
    end
    repeat (4) @(negedge clk_a);
    repeat (4) @(negedge clk_b);
    @(negedge clk_a); rst_a = 1'b0;
    @(negedge clk_b); rst_b = 1'b0;
    repeat (2) @(negedge clk_a);
  endtask

  // concurrent traffic in both directions, readers starting late so full is hit
  task automatic both_ways(input string tag);
    fork
      burst_a(150);
      begin repeat (80) @(negedge clk_b); drain_b(150); end
      burst_b(150);
      begin repeat (70) @(negedge clk_a); drain_a(150); end
    join
    settle();
    chk(qab.size() == 0, {tag, " A-to-B all delivered"}, DW'(qab.size()), '0);
    chk(qba.size() == 0, {tag, " B-to-A all delivered"}, DW'(qba.size()), '0);
    chk(b_empty == 1'b1, {tag, " A-to-B empty after traffic"}, DW'(b_empty), 1);
    chk(a_empty == 1'b1, {tag, " B-to-A empty after traffic"}, DW'(a_empty), 1);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk_a);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] lastw;
    rst_a = 1'b1; rst_b = 1'b1;
    a_wr_en = 0; a_rd_en = 0; a_cfg_we = 0; a_cfg_sel = 0; a_cfg_val = '0; a_wr_data = '0;
    b_wr_en = 0; b_rd_en = 0; b_cfg_we = 0; b_cfg_sel = 0; b_cfg_val = '0; b_wr_data = '0;
    do_reset(1'b0, 1'b0, 0, 0, 0, 0);

    // reset state: R11, R5
    chk(a_empty == 1'b1, "R5 B-to-A empty after reset", DW'(a_empty), 1);
    chk(b_empty == 1'b1, "R5 A-to-B empty after reset", DW'(b_empty), 1);
    chk(a_full == 1'b0, "R11 A-to-B full low", DW'(a_full), 0);
    chk(b_full == 1'b0, "R11 B-to-A full low", DW'(b_full), 0);
    chk(a_afull == 1'b0, "R11 A-to-B almost-full low", DW'(a_afull), 0);
    chk(b_afull == 1'b0, "R11 B-to-A almost-full low", DW'(b_afull), 0);
    chk(a_aempty == 1'b1, "R11 B-to-A almost-empty high", DW'(a_aempty), 1);
    chk(b_aempty == 1'b1, "R11 A-to-B almost-empty high", DW'(b_aempty), 1);
    chk(a_rd_data == '0, "R11 port A read data cleared", a_rd_data, '0);
    chk(b_rd_data == '0, "R11 port B read data cleared", b_rd_data, '0);

    // R1: both directions, first sequential then overlapping
    fork burst_a(20); burst_b(20); join
    fork drain_b(20); drain_a(20); join
    fork burst_a(30); drain_b(30); burst_b(30); drain_a(30); join
    settle();
    chk(qab.size() == 0, "R1 A-to-B queue drained", DW'(qab.size()), '0);
    chk(qba.size() == 0, "R1 B-to-A queue drained", DW'(qba.size()), '0);

    // R6: default almost-empty offset 8
    repeat (8) wr_a(1'b1);
    settle();
    chk(b_aempty == 1'b1, "R6 8 words stored, almost-empty", DW'(b_aempty), 1);
    chk(b_empty == 1'b0, "R5 empty falls after writes", DW'(b_empty), 0);
    wr_a(1'b1);
    settle();
    chk(b_aempty == 1'b0, "R6 9 words stored, not almost-empty", DW'(b_aempty), 0);
    drain_b(9);
    settle();
    chk(b_empty == 1'b1, "R5 empty after last word read", DW'(b_empty), 1);

    // R7, R2, R3: fill to full, then overrun
    repeat (55) wr_a(1'b1);
    settle();
    chk(a_afull == 1'b0, "R7 55 stored, free 9, not almost-full", DW'(a_afull), 0);
    wr_a(1'b1);
    settle();
    chk(a_afull == 1'b1, "R7 56 stored, free 8, almost-full", DW'(a_afull), 1);
    repeat (7) wr_a(1'b1);
    chk(a_full == 1'b0, "R2 63 stored, not full", DW'(a_full), 0);
    lastw = word(seq);
    wr_a(1'b1);
    chk(a_full == 1'b1, "R2 64 stored, full on accepting edge", DW'(a_full), 1);
    repeat (3) wr_a(1'b0);
    settle();
    chk(a_full == 1'b1, "R3 full holds after dropped writes", DW'(a_full), 1);
    drain_b(64);
    settle();
    chk(qab.size() == 0, "R3 exactly 64 stored words delivered", DW'(qab.size()), '0);
    chk(b_empty == 1'b1, "R3 nothing beyond 64 words", DW'(b_empty), 1);
    chk(a_full == 1'b0, "R2 full clears after draining", DW'(a_full), 0);

    // R4: reads against an empty buffer
    repeat (4) begin
      @(negedge clk_b); b_rd_en = 1'b1;
    end
    @(negedge clk_b); b_rd_en = 1'b0;
    chk(b_rd_data == lastw, "R4 read data holds on empty read", b_rd_data, lastw);
    chk(b_empty == 1'b1, "R4 empty stays after empty reads", DW'(b_empty), 1);
    wr_a(1'b1);
    drain_b(1);
    settle();
    chk(qab.size() == 0, "R4 next written word is next read", DW'(qab.size()), '0);

    // R8: loaded offsets, and loads outside reset ignored
    do_reset(1'b0, 1'b1, 5, 3, 2, 10);
    @(negedge clk_a); a_cfg_we = 1'b1; a_cfg_sel = 1'b1; a_cfg_val = 6'd20;
    @(negedge clk_a); a_cfg_we = 1'b0;
    @(negedge clk_b); b_cfg_we = 1'b1; b_cfg_sel = 1'b0; b_cfg_val = 6'd30;
    @(negedge clk_b); b_cfg_we = 1'b0;
    repeat (2) wr_a(1'b1);
    settle();
    chk(b_aempty == 1'b1, "R8 A-to-B low mark 2, 2 stored", DW'(b_aempty), 1);
    wr_a(1'b1);
    settle();
    chk(b_aempty == 1'b0, "R8 A-to-B low mark 2, 3 stored", DW'(b_aempty), 0);
    repeat (57) wr_a(1'b1);
    settle();
    chk(a_afull == 1'b0, "R8 A-to-B high mark 3, free 4", DW'(a_afull), 0);
    wr_a(1'b1);
    settle();
    chk(a_afull == 1'b1, "R8 A-to-B high mark 3, free 3", DW'(a_afull), 1);
    drain_b(61);
    repeat (5) wr_b(1'b1);
    settle();
    chk(a_aempty == 1'b1, "R8 B-to-A low mark 5, 5 stored", DW'(a_aempty), 1);
    wr_b(1'b1);
    settle();
    chk(a_aempty == 1'b0, "R8 B-to-A low mark 5, 6 stored", DW'(a_aempty), 0);
    repeat (47) wr_b(1'b1);
    settle();
    chk(b_afull == 1'b0, "R8 B-to-A high mark 10, free 11", DW'(b_afull), 0);
    wr_b(1'b1);
    settle();
    chk(b_afull == 1'b1, "R8 B-to-A high mark 10, free 10", DW'(b_afull), 1);
    drain_a(54);
    settle();
    chk(qab.size() == 0 && qba.size() == 0, "R8 all words delivered",
        DW'(qab.size() + qba.size()), '0);

    // R10: identical clocks; R8 default restored by a reset without loads
    do_reset(1'b1, 1'b0, 0, 0, 0, 0);
    repeat (8) wr_a(1'b1);
    settle();
    chk(b_aempty == 1'b1, "R8 default low mark back to 8, 8 stored", DW'(b_aempty), 1);
    wr_a(1'b1);
    settle();
    chk(b_aempty == 1'b0, "R8 default low mark back to 8, 9 stored", DW'(b_aempty), 0);
    drain_b(9);
    both_ways("R10 identical clocks");

    // R10: unrelated clocks
    do_reset(1'b0, 1'b0, 0, 0, 0, 0);
    both_ways("R10 unrelated clocks");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule